// File: doc/BRIEF.md
# Load-Store Disambiguation Queue

This block keeps the memory operations of a processor core in program order, from allocation until they retire at the head. Each store reaches the block in two separate steps, one when its address is computed and one when its data is written. Each load asks the block for permission to go to memory. The block compares the load's address with the address of every older store still in the queue and grants the load only when no older store could alias it. Stores themselves reach memory in queue order when they retire, which the surrounding core carries out.

The comparison uses only the low 12 address bits, so callers pass only those bits in. If two addresses have equal low bits, the block treats them as a conflict. In conservative operation, a load also waits while any older store still has an unknown address. In speculative operation, a load may run ahead of such a store. If that store's address later turns out to match the executed load, the block reports a squash for that load. The same report records the load's PC index in a small predictor table. Later loads with that PC index then wait until every older store has completed both of its steps. The predictor forgets everything at a fixed interval. The core recovers from a squash itself, by flushing every entry younger than a chosen index.

Top module: `mem_order_queue`

## Requirements
- R1: After reset the queue is empty (q_empty=1, q_full=0), alloc_idx is 0, and neither ld_grant nor squash_vld is asserted.
- R2: A request to allocate takes the slot shown on alloc_idx. alloc_idx then advances by one, modulo 16. After 16 allocations q_full is 1, and further allocation requests change nothing.
- R3: A commit removes the oldest entry. Once every entry has been committed, q_empty is 1. A commit on an empty queue has no effect.
- R4: A load is granted in the same cycle it asks, when every older store in the queue has a known address whose low 12 bits differ from the load's.
- R5: A load is refused when an older store has a known address whose low 12 bits equal the load's.
- R6: With speculate=0, a load is refused while any older store's address is still unknown.
- R7: Stores younger than a load never hold it back. With speculate=1 and the load's wait bit clear, an older store with an unknown address does not hold it back either.
- R8: When a store's address resolves, squash_vld rises in that same cycle if a younger load has already executed with the same low 12 bits. squash_idx then gives the oldest such load. An older load with a matching address causes no squash.
- R9: A load can be granted in the same cycle that an older store's address resolves with the same low 12 bits. In that case the load counts as executed, and the squash names it.
- R10: A squash sets the wait bit selected by the squashed load's 6-bit PC index. A later load with that index is refused, even with speculate=1, until every older store has both its address and its data done. Loads with other indexes are not affected.
- R11: All wait bits are cleared once every 4096 cycles, counted from the release of reset.
- R12: A flush marks every entry younger than flush_idx as free, and alloc_idx becomes flush_idx+1. A flush that names a free slot is ignored.
- R13: A valid flush takes priority over an allocation or a commit requested in the same cycle. Both of those are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speculate | input | 1 | 1 lets loads pass older stores whose address is unknown |
| alloc_vld | input | 1 | Allocate one entry at the tail |
| alloc_is_st | input | 1 | Entry being allocated is a store (1) or a load (0) |
| alloc_pc_lo | input | 6 | Low PC bits of the operation, used as the predictor index |
| alloc_idx | output | 4 | Slot the next allocation takes |
| q_full | output | 1 | All 16 slots are in use |
| q_empty | output | 1 | No slot is in use |
| st_addr_vld | input | 1 | A store's address has been computed |
| st_addr_idx | input | 4 | Slot of that store |
| st_addr_lo | input | 12 | Low address bits of that store |
| st_data_vld | input | 1 | A store's data has been written |
| st_data_idx | input | 4 | Slot of that store |
| ld_req_vld | input | 1 | A load asks to execute |
| ld_req_idx | input | 4 | Slot of the load |
| ld_req_lo | input | 12 | Low address bits of the load |
| ld_grant | output | 1 | The load may execute this cycle |
| squash_vld | output | 1 | Ordering violation found |
| squash_idx | output | 4 | Slot of the oldest load that violated ordering |
| commit_vld | input | 1 | Retire the head entry |
| flush_vld | input | 1 | Drop the entries younger than flush_idx |
| flush_idx | input | 4 | Youngest slot that survives the flush |

## Verification
A load's request for permission and the address resolution of an older store can fall in the same cycle. This is the case where a check against registered state alone would miss a dependence. The bench allocates a store and a younger load, then drives the load request and the store address in one cycle. It uses equal low address bits in one run and different low bits in the other. In the matching run, ld_grant and squash_vld must both be set and squash_idx must name the load. In the other run, the grant must arrive without a squash.

// File: rtl/moq_pkg.sv
package moq_pkg;

  // Per-slot status kept for every queue entry.
  typedef struct packed {
    logic vld;      // slot in use
    logic is_st;    // store (1) or load (0)
    logic addr_ok;  // store address phase complete
    logic data_ok;  // store data phase complete
    logic ld_done;  // load has been allowed to execute
  } ent_flags_t;

endpackage

// File: rtl/moq_order_ctl.sv
module moq_order_ctl #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_go,
  input  logic          commit_go,
  input  logic          flush_go,
  input  logic [IW-1:0] flush_idx,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic          full,
  output logic          empty
);

  logic [IW:0]   cnt, cnt_n;
  logic [IW-1:0] head_n, tail_n;

  always_comb begin
    head_n = head;
    tail_n = tail;
    cnt_n  = cnt;
    if (flush_go) begin
      tail_n = flush_idx + IW'(1);
      cnt_n  = {1'b0, flush_idx - head} + (IW+1)'(1);
    end else begin
      if (alloc_go)  tail_n = tail + IW'(1);
      if (commit_go) head_n = head + IW'(1);
      cnt_n = cnt + (IW+1)'(alloc_go) - (IW+1)'(commit_go);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      head <= head_n;
      tail <= tail_n;
      cnt  <= cnt_n;
    end
  end

  assign full  = (cnt == (IW+1)'(DEPTH));
  assign empty = (cnt == '0);

endmodule

// File: rtl/moq_dep_check.sv
module moq_dep_check
  import moq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 12,
  localparam int IW = $clog2(DEPTH)
) (
  input  ent_flags_t [DEPTH-1:0]         fl,
  input  logic       [DEPTH-1:0][CW-1:0] ea,
  input  logic       [IW-1:0]            head,
  input  logic                           speculate,
  input  logic                           wait_hit,
  input  logic                           ld_req_vld,
  input  logic       [IW-1:0]            ld_req_idx,
  input  logic       [CW-1:0]            ld_req_lo,
  input  logic                           st_res_vld,
  input  logic       [IW-1:0]            st_res_idx,
  input  logic       [CW-1:0]            st_res_lo,
  output logic                           ld_grant,
  output logic                           squash_vld,
  output logic       [IW-1:0]            squash_idx
);

  // Grant: scan every older store for an alias or an unresolved address.
  always_comb begin
    logic [IW-1:0] ld_age;
    logic [IW-1:0] age_i;
    logic          req_ok;
    logic          older;
    logic          block;
    ld_age = ld_req_idx - head;
    req_ok = ld_req_vld && fl[ld_req_idx].vld && !fl[ld_req_idx].is_st
             && !fl[ld_req_idx].ld_done;
    block  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      age_i = IW'(i) - head;
      older = fl[i].vld && fl[i].is_st && (age_i < ld_age);
      if (older) begin
        if (fl[i].addr_ok) begin
          if (ea[i] == ld_req_lo) block = 1'b1;
        end else if (!speculate || wait_hit) begin
          block = 1'b1;
        end
        if (wait_hit && !fl[i].data_ok) block = 1'b1;
      end
    end
    ld_grant = req_ok && !block;
  end

  // Violation: younger executed loads (including one granted right now)
  // whose address matches the store resolving this cycle; oldest wins.
  always_comb begin
    logic [IW-1:0] st_age;
    logic [IW-1:0] j;
    logic [CW-1:0] la;
    logic          st_ok;
    logic          exec_j;
    st_age     = st_res_idx - head;
    st_ok      = st_res_vld && fl[st_res_idx].vld && fl[st_res_idx].is_st;
    squash_vld = 1'b0;
    squash_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      j      = head + IW'(k);
      exec_j = fl[j].ld_done || (ld_grant && (ld_req_idx == j));
      la     = (ld_grant && (ld_req_idx == j)) ? ld_req_lo : ea[j];
      if (st_ok && fl[j].vld && !fl[j].is_st && (IW'(k) > st_age)
          && exec_j && (la == st_res_lo)) begin
        squash_vld = 1'b1;
        squash_idx = j;
      end
    end
  end

endmodule

// File: rtl/moq_wait_table.sv
module moq_wait_table #(
  parameter int ENTRIES = 64,
  parameter int PERIOD  = 4096,
  localparam int XW = $clog2(ENTRIES),
  localparam int CNTW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] rd_idx,
  output logic          rd_bit,
  input  logic          set_vld,
  input  logic [XW-1:0] set_idx
);

  logic [ENTRIES-1:0] bits, bits_n;
  logic [CNTW-1:0]    cnt, cnt_n;
  logic               clr;

  always_comb begin
    clr    = (cnt == CNTW'(PERIOD - 1));
    cnt_n  = clr ? '0 : cnt + CNTW'(1);
    bits_n = clr ? '0 : bits;
    if (set_vld) bits_n[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
      cnt  <= '0;
    end else begin
      bits <= bits_n;
      cnt  <= cnt_n;
    end
  end

  assign rd_bit = bits[rd_idx];

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import moq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CMP_W      = 12,
  parameter int WT_ENTRIES = 64,
  parameter int WT_PERIOD  = 4096,
  localparam int IW  = $clog2(DEPTH),
  localparam int WTW = $clog2(WT_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             speculate,
  input  logic             alloc_vld,
  input  logic             alloc_is_st,
  input  logic [WTW-1:0]   alloc_pc_lo,
  output logic [IW-1:0]    alloc_idx,
  output logic             q_full,
  output logic             q_empty,
  input  logic             st_addr_vld,
  input  logic [IW-1:0]    st_addr_idx,
  input  logic [CMP_W-1:0] st_addr_lo,
  input  logic             st_data_vld,
  input  logic [IW-1:0]    st_data_idx,
  input  logic             ld_req_vld,
  input  logic [IW-1:0]    ld_req_idx,
  input  logic [CMP_W-1:0] ld_req_lo,
  output logic             ld_grant,
  output logic             squash_vld,
  output logic [IW-1:0]    squash_idx,
  input  logic             commit_vld,
  input  logic             flush_vld,
  input  logic [IW-1:0]    flush_idx
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rsync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i_n = rsync[1];

  ent_flags_t [DEPTH-1:0]            fl, fl_n;
  logic       [DEPTH-1:0][CMP_W-1:0] ea, ea_n;
  logic       [DEPTH-1:0][WTW-1:0]   pcx, pcx_n;

  logic [IW-1:0] head, tail;
  logic          alloc_go, commit_go, flush_go;
  logic          wait_hit;

  assign flush_go  = flush_vld && fl[flush_idx].vld;
  assign alloc_go  = alloc_vld && !q_full && !flush_go;
  assign commit_go = commit_vld && !q_empty && !flush_go;

  moq_order_ctl #(.DEPTH(DEPTH)) u_ord (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .alloc_go  (alloc_go),
    .commit_go (commit_go),
    .flush_go  (flush_go),
    .flush_idx (flush_idx),
    .head      (head),
    .tail      (tail),
    .full      (q_full),
    .empty     (q_empty)
  );

  moq_dep_check #(.DEPTH(DEPTH), .CW(CMP_W)) u_dep (
    .fl         (fl),
    .ea         (ea),
    .head       (head),
    .speculate  (speculate),
    .wait_hit   (wait_hit),
    .ld_req_vld (ld_req_vld),
    .ld_req_idx (ld_req_idx),
    .ld_req_lo  (ld_req_lo),
    .st_res_vld (st_addr_vld),
    .st_res_idx (st_addr_idx),
    .st_res_lo  (st_addr_lo),
    .ld_grant   (ld_grant),
    .squash_vld (squash_vld),
    .squash_idx (squash_idx)
  );

  moq_wait_table #(.ENTRIES(WT_ENTRIES), .PERIOD(WT_PERIOD)) u_wt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_idx  (pcx[ld_req_idx]),
    .rd_bit  (wait_hit),
    .set_vld (squash_vld),
    .set_idx (pcx[squash_idx])
  );

  // Entry state next-value logic.
  always_comb begin
    logic [IW-1:0] rel_i;
    logic [IW-1:0] rel_f;
    fl_n  = fl;
    ea_n  = ea;
    pcx_n = pcx;
    if (alloc_go) begin
      fl_n[tail].vld     = 1'b1;
      fl_n[tail].is_st   = alloc_is_st;
      fl_n[tail].addr_ok = 1'b0;
      fl_n[tail].data_ok = 1'b0;
      fl_n[tail].ld_done = 1'b0;
      pcx_n[tail]        = alloc_pc_lo;
    end
    if (st_addr_vld && fl[st_addr_idx].vld && fl[st_addr_idx].is_st) begin
      fl_n[st_addr_idx].addr_ok = 1'b1;
      ea_n[st_addr_idx]         = st_addr_lo;
    end
    if (st_data_vld && fl[st_data_idx].vld && fl[st_data_idx].is_st)
      fl_n[st_data_idx].data_ok = 1'b1;
    if (ld_grant) begin
      fl_n[ld_req_idx].ld_done = 1'b1;
      ea_n[ld_req_idx]         = ld_req_lo;
    end
    if (commit_go) fl_n[head].vld = 1'b0;
    rel_f = flush_idx - head;
    for (int i = 0; i < DEPTH; i++) begin
      rel_i = IW'(i) - head;
      if (flush_go && (rel_i > rel_f)) fl_n[i].vld = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fl  <= '0;
      ea  <= '0;
      pcx <= '0;
    end else begin
      fl  <= fl_n;
      ea  <= ea_n;
      pcx <= pcx_n;
    end
  end

  assign alloc_idx = tail;

endmodule

// File: rtl/moq_checker.sv
module moq_checker #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_vld,
  input logic [IW-1:0] alloc_idx,
  input logic          q_full,
  input logic          q_empty,
  input logic          st_addr_vld,
  input logic [IW-1:0] st_addr_idx,
  input logic          ld_req_vld,
  input logic          ld_grant,
  input logic          squash_vld,
  input logic [IW-1:0] squash_idx,
  input logic          commit_vld,
  input logic          flush_vld
);

  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty)); // R2

  AST_ALLOC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld && !q_full && !flush_vld |=> alloc_idx == IW'($past(alloc_idx) + 1'b1)); // R2

  AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && !commit_vld && !flush_vld |=> q_full); // R2

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !ld_grant && !squash_vld); // R3

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_grant |-> ld_req_vld); // R4

  AST_SQUASH_HAS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    squash_vld |-> st_addr_vld); // R8

  AST_SQUASH_NOT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    squash_vld |-> squash_idx != st_addr_idx); // R8

endmodule

bind mem_order_queue moq_checker #(.IW(IW)) u_chk (.*);

// File: tb/tb_mem_order_queue.sv
module tb_mem_order_queue;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        speculate;
  logic        alloc_vld, alloc_is_st;
  logic [5:0]  alloc_pc_lo;
  logic [3:0]  alloc_idx;
  logic        q_full, q_empty;
  logic        st_addr_vld;
  logic [3:0]  st_addr_idx;
  logic [11:0] st_addr_lo;
  logic        st_data_vld;
  logic [3:0]  st_data_idx;
  logic        ld_req_vld;
  logic [3:0]  ld_req_idx;
  logic [11:0] ld_req_lo;
  logic        ld_grant, squash_vld;
  logic [3:0]  squash_idx;
  logic        commit_vld, flush_vld;
  logic [3:0]  flush_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mem_order_queue dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    alloc_vld = 0; alloc_is_st = 0; alloc_pc_lo = '0;
    st_addr_vld = 0; st_addr_idx = '0; st_addr_lo = '0;
    st_data_vld = 0; st_data_idx = '0;
    ld_req_vld = 0; ld_req_idx = '0; ld_req_lo = '0;
    commit_vld = 0; flush_vld = 0; flush_idx = '0;
  endtask

  task automatic do_reset();
    idle_in();
    speculate = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic alloc(input bit st, input int pc);
    alloc_vld = 1; alloc_is_st = st; alloc_pc_lo = 6'(pc);
    @(negedge clk);
    alloc_vld = 0;
  endtask

  task automatic ld_try(input int idx, input int a, input int exp, input string req);
    ld_req_vld = 1; ld_req_idx = 4'(idx); ld_req_lo = 12'(a);
    #2 chk(req, ld_grant, exp);
    @(negedge clk);
    ld_req_vld = 0;
  endtask

  task automatic st_res(input int idx, input int a, input int exp_sq, input int exp_idx,
                        input string req);
    st_addr_vld = 1; st_addr_idx = 4'(idx); st_addr_lo = 12'(a);
    #2 chk(req, squash_vld, exp_sq);
    if (exp_sq != 0) chk(req, squash_idx, exp_idx);
    @(negedge clk);
    st_addr_vld = 0;
  endtask

  task automatic st_data(input int idx);
    st_data_vld = 1; st_data_idx = 4'(idx);
    @(negedge clk);
    st_data_vld = 0;
  endtask

  task automatic commit1();
    commit_vld = 1;
    @(negedge clk);
    commit_vld = 0;
  endtask

  task automatic flush_at(input int idx);
    flush_vld = 1; flush_idx = 4'(idx);
    @(negedge clk);
    flush_vld = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty", q_empty, 1);
    chk("R1 full", q_full, 0);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 grant", ld_grant, 0);
    chk("R1 squash", squash_vld, 0);
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 16; i++) begin
      chk("R2 alloc order", alloc_idx, i);
      alloc(0, i);
    end
    chk("R2 full", q_full, 1);
    alloc(1, 0);
    chk("R2 alloc ignored when full", alloc_idx, 0);
    chk("R2 still full", q_full, 1);
    for (int i = 0; i < 16; i++) commit1();
    chk("R3 empty after commits", q_empty, 1);
    commit1();
    chk("R3 empty commit no effect", q_empty, 1);
    alloc(0, 0);
    chk("R3 head kept after empty commit", alloc_idx, 1);
    chk("R3 not empty", q_empty, 0);
  endtask

  task automatic t_bypass();
    do_reset();
    speculate = 0;
    alloc(1, 1);  // store, slot 0
    alloc(0, 2);  // load, slot 1
    ld_try(1, 'h234, 0, "R6 unknown older store blocks");
    st_res(0, 'h678, 0, 0, "R8 no younger executed load");
    ld_try(1, 'h234, 1, "R4 non-aliasing older store");
    alloc(1, 3);  // store, slot 2
    alloc(0, 4);  // load, slot 3
    st_res(2, 'h234, 0, 0, "R8 older load match no squash");
    ld_try(3, 'h234, 0, "R5 low bits match blocks");
    ld_try(3, 'h235, 1, "R4 differing low bits grant");
  endtask

  task automatic t_spec();
    do_reset();
    alloc(0, 5);   // load, slot 0
    alloc(1, 6);   // store, slot 1
    alloc(0, 9);   // load, slot 2
    alloc(0, 20);  // load, slot 3
    speculate = 0;
    ld_try(0, 'h100, 1, "R7 younger store never blocks");
    speculate = 1;
    ld_try(2, 'h200, 1, "R7 speculate past unknown store");
    ld_try(3, 'h200, 1, "R7 speculate second load");
    st_res(1, 'h100, 0, 0, "R8 match only with older load");
    st_res(1, 'h200, 1, 2, "R8 oldest younger load squashed");
    flush_at(1);
    chk("R12 flush moves tail", alloc_idx, 2);
    alloc(0, 9);   // slot 2, same PC index as squashed load
    alloc(0, 10);  // slot 3, other PC index
    ld_try(3, 'h500, 1, "R10 other PC index unaffected");
    ld_try(2, 'h400, 0, "R10 wait bit holds load");
    st_data(1);
    ld_try(2, 'h400, 1, "R10 released after store complete");
  endtask

  task automatic t_same_cycle(input bit match);
    do_reset();
    speculate = 1;
    alloc(1, 1);  // store, slot 0
    alloc(0, 2);  // load, slot 1
    ld_req_vld = 1; ld_req_idx = 4'd1; ld_req_lo = 12'h0AB;
    st_addr_vld = 1; st_addr_idx = 4'd0; st_addr_lo = match ? 12'h0AB : 12'h0AC;
    #2;
    chk("R9 grant in same cycle", ld_grant, 1);
    chk("R9 squash in same cycle", squash_vld, match ? 1 : 0);
    if (match) chk("R9 squash names load", squash_idx, 1);
    @(negedge clk);
    ld_req_vld = 0; st_addr_vld = 0;
  endtask

  task automatic t_wait_clear();
    do_reset();
    speculate = 1;
    alloc(1, 1);  // store, slot 0
    alloc(0, 3);  // load, slot 1
    ld_try(1, 'h050, 1, "R7 speculative grant");
    st_res(0, 'h050, 1, 1, "R8 violation");
    flush_at(0);
    alloc(0, 3);  // slot 1 again, same PC index
    ld_try(1, 'h060, 0, "R10 wait bit set");
    repeat (4200) @(negedge clk);
    ld_try(1, 'h060, 1, "R11 wait bits cleared");
  endtask

  task automatic t_flush_prio();
    do_reset();
    alloc(0, 0); alloc(0, 1); alloc(0, 2);
    flush_vld = 1; flush_idx = 4'd0; alloc_vld = 1; commit_vld = 1;
    @(negedge clk);
    flush_vld = 0; alloc_vld = 0; commit_vld = 0;
    chk("R13 flush beats alloc", alloc_idx, 1);
    chk("R13 flush beats commit", q_empty, 0);
    commit1();
    chk("R3 empty after last commit", q_empty, 1);
    alloc(0, 4);
    chk("R12 alloc after flush", alloc_idx, 2);
    flush_at(7);
    chk("R12 flush of free slot ignored", alloc_idx, 2);
  endtask

  initial begin
    t_reset();
    t_order();
    t_bypass();
    t_spec();
    t_same_cycle(1);
    t_same_cycle(0);
    t_wait_clear();
    t_flush_prio();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule